// File: doc/BRIEF.md
# Dual-Output Paired-Function ALU

This block is a purely combinational arithmetic and logic unit. It takes two operands, A and B, and a 3-bit operation code. It then drives two result buses, YA and YB, at the same time. Each code selects a pair of related functions, so a single operation returns two useful answers:

- Addition returns a full-width sum on one output. On the other it returns A plus the low half of B, sign-extended to full width. Adding a short relative offset therefore needs no separate sign-extend step.
- Subtraction works the same way, with the full-width difference on one output and the sign-extended form on the other.
- Multiplication splits the double-width product across the two outputs.
- Bitwise operations give AND with OR, and XOR with XNOR.
- A halfword swap exchanges the two halves of each operand.

Each output carries its own four status flags: zero, negative, carry and overflow. A surrounding datapath can take either result, or any single flag, as its write-back value. Operand selection, register storage and pipelining belong to the surrounding logic. The operand width is a parameter, and the half width must be exactly half of it. A parameter also selects whether the multiply treats the operands as signed. The default is unsigned.

Top module: `pair_alu`

## Requirements
- R1: With op_i = 3'b000, ya_o equals a_i and yb_o equals b_i.
- R2: With op_i = 3'b001, ya_o = a_i + b_i modulo 2^32. yb_o = a_i + SX(b_i[15:0]) modulo 2^32, where SX sign-extends bit 15 to 32 bits.
- R3: With op_i = 3'b010, ya_o = a_i - b_i and yb_o = a_i - SX(b_i[15:0]), both modulo 2^32.
- R4: With op_i = 3'b011, the unsigned 64-bit product a_i*b_i has its upper 32 bits on ya_o and its lower 32 bits on yb_o.
- R5: With op_i = 3'b100, ya_o = a_i AND b_i and yb_o = a_i OR b_i.
- R6: With op_i = 3'b101, ya_o = a_i XOR b_i and yb_o = NOT(a_i XOR b_i).
- R7: With op_i = 3'b111, ya_o = {a_i[15:0], a_i[31:16]} and yb_o = {b_i[15:0], b_i[31:16]}.
- R8: With the reserved code op_i = 3'b110, both results are zero, whatever the operands. Their flags follow R9 and R12 (Z = 1, all other flags 0).
- R9: Each flag group is laid out as bit 3 = Z, bit 2 = N, bit 1 = C, bit 0 = V. Z is 1 exactly when that output's result is all zeros, and N equals bit 31 of that result.
- R10: For the add code, C is the carry out of bit 31 of that output's sum. V is 1 when both addends have the same sign and the sum's sign differs from it.
- R11: For the subtract code, C is 1 when a borrow occurs, that is, when the minuend is unsigned-less than the subtrahend. V is 1 when the operand signs differ and the result's sign differs from the minuend's.
- R12: For every code other than add and subtract, C and V are 0 in both flag groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 3 | Operation code |
| ya_o | output | 32 | First result |
| yb_o | output | 32 | Second result |
| flags_a_o | output | 4 | Z, N, C, V flags of ya_o |
| flags_b_o | output | 4 | Z, N, C, V flags of yb_o |

## Verification
There is no register between the operand and opcode inputs and any result or flag. Every output is therefore due in the same cycle its inputs change, with zero cycles of latency. The bench changes the inputs just after a falling clock edge. It samples both results and both flag groups one nanosecond later, well before the next rising edge. Each check thus sees a fully settled combinational answer and never a value caught mid-change at an edge.

// File: rtl/pair_alu_pkg.sv
package pair_alu_pkg;

   typedef enum logic [2:0] {
      OP_PASS  = 3'b000,
      OP_ADD   = 3'b001,
      OP_SUB   = 3'b010,
      OP_MUL   = 3'b011,
      OP_ANDOR = 3'b100,
      OP_XOR   = 3'b101,
      OP_RSVD  = 3'b110,
      OP_SWAP  = 3'b111
   } pair_op_e;

   typedef struct packed {
      logic z;
      logic n;
      logic c;
      logic v;
   } pair_flags_t;

endpackage

// File: rtl/pair_addsub.sv
module pair_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o,
   output logic         ovf_o
);
   logic [W-1:0] b_eff;
   logic [W:0]   raw;

   always_comb begin
      b_eff   = sub_i ? ~b_i : b_i;
      raw     = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
      sum_o   = raw[W-1:0];
      // for subtraction a missing carry-out means a borrow
      carry_o = raw[W] ^ sub_i;
      ovf_o   = (a_i[W-1] == b_eff[W-1]) && (raw[W-1] != a_i[W-1]);
   end
endmodule

// File: rtl/pair_mult.sv
module pair_mult #(
   parameter int W         = 32,
   parameter bit IS_SIGNED = 1'b0
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic [2*W-1:0] prod_o
);
   generate
      if (IS_SIGNED) begin : g_signed
         assign prod_o = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
      end else begin : g_unsigned
         assign prod_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
      end
   endgenerate
endmodule

// File: rtl/pair_bitops.sv
module pair_bitops #(
   parameter int W = 32,
   parameter int H = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] and_o,
   output logic [W-1:0] or_o,
   output logic [W-1:0] xor_o,
   output logic [W-1:0] xnor_o,
   output logic [W-1:0] swap_a_o,
   output logic [W-1:0] swap_b_o
);
   assign and_o    = a_i & b_i;
   assign or_o     = a_i | b_i;
   assign xor_o    = a_i ^ b_i;
   assign xnor_o   = ~(a_i ^ b_i);
   assign swap_a_o = {a_i[H-1:0], a_i[W-1:H]};
   assign swap_b_o = {b_i[H-1:0], b_i[W-1:H]};
endmodule

// File: rtl/pair_flags.sv
module pair_flags
   import pair_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] res_i,
   input  logic         arith_i,
   input  logic         carry_i,
   input  logic         ovf_i,
   output pair_flags_t  flags_o
);
   always_comb begin
      flags_o.z = (res_i == '0);
      flags_o.n = res_i[W-1];
      flags_o.c = arith_i & carry_i;
      flags_o.v = arith_i & ovf_i;
   end
endmodule

// File: rtl/pair_alu.sv
module pair_alu
   import pair_alu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int HALF_W     = 16,
   parameter bit MUL_SIGNED = 1'b0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [2:0]        op_i,
   output logic [DATA_W-1:0] ya_o,
   output logic [DATA_W-1:0] yb_o,
   output logic [3:0]        flags_a_o,
   output logic [3:0]        flags_b_o
);
   localparam int EXT_W  = DATA_W - HALF_W;
   localparam int PROD_W = 2 * DATA_W;
   localparam int LANES  = 2;

   generate
      if (DATA_W != 2 * HALF_W) begin : g_bad_half
         $error("pair_alu: HALF_W must be exactly half of DATA_W");
      end
      if (DATA_W < 4) begin : g_bad_width
         $error("pair_alu: DATA_W must be at least 4");
      end
   endgenerate

   pair_op_e op;
   assign op = pair_op_e'(op_i);

   logic is_sub, is_arith;
   assign is_sub   = (op == OP_SUB);
   assign is_arith = (op == OP_ADD) || (op == OP_SUB);

   // lane 0 uses B at full width, lane 1 uses the sign-extended low half
   logic [DATA_W-1:0] lane_b   [LANES];
   logic [DATA_W-1:0] as_sum   [LANES];
   logic              as_c     [LANES];
   logic              as_v     [LANES];
   logic [DATA_W-1:0] lane_res [LANES];
   pair_flags_t       lane_fl  [LANES];

   assign lane_b[0] = b_i;
   assign lane_b[1] = {{EXT_W{b_i[HALF_W-1]}}, b_i[HALF_W-1:0]};

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         pair_addsub #(.W(DATA_W)) u_addsub (
            .a_i     (a_i),
            .b_i     (lane_b[g]),
            .sub_i   (is_sub),
            .sum_o   (as_sum[g]),
            .carry_o (as_c[g]),
            .ovf_o   (as_v[g])
         );
         pair_flags #(.W(DATA_W)) u_flags (
            .res_i   (lane_res[g]),
            .arith_i (is_arith),
            .carry_i (as_c[g]),
            .ovf_i   (as_v[g]),
            .flags_o (lane_fl[g])
         );
      end
   endgenerate

   logic [PROD_W-1:0] prod;
   pair_mult #(.W(DATA_W), .IS_SIGNED(MUL_SIGNED)) u_mult (
      .a_i    (a_i),
      .b_i    (b_i),
      .prod_o (prod)
   );

   logic [DATA_W-1:0] and_v, or_v, xor_v, xnor_v, swap_a, swap_b;
   pair_bitops #(.W(DATA_W), .H(HALF_W)) u_bitops (
      .a_i      (a_i),
      .b_i      (b_i),
      .and_o    (and_v),
      .or_o     (or_v),
      .xor_o    (xor_v),
      .xnor_o   (xnor_v),
      .swap_a_o (swap_a),
      .swap_b_o (swap_b)
   );

   always_comb begin
      case (op)
         OP_PASS:  begin lane_res[0] = a_i;       lane_res[1] = b_i;       end
         OP_ADD,
         OP_SUB:   begin lane_res[0] = as_sum[0]; lane_res[1] = as_sum[1]; end
         OP_MUL:   begin lane_res[0] = prod[PROD_W-1:DATA_W];
                         lane_res[1] = prod[DATA_W-1:0];                   end
         OP_ANDOR: begin lane_res[0] = and_v;     lane_res[1] = or_v;      end
         OP_XOR:   begin lane_res[0] = xor_v;     lane_res[1] = xnor_v;    end
         OP_SWAP:  begin lane_res[0] = swap_a;    lane_res[1] = swap_b;    end
         default:  begin lane_res[0] = '0;        lane_res[1] = '0;        end
      endcase
   end

   assign ya_o      = lane_res[0];
   assign yb_o      = lane_res[1];
   assign flags_a_o = lane_fl[0];
   assign flags_b_o = lane_fl[1];

   // Inverse-operation and cross-output checks on the port values
   always_comb begin
      if (op == OP_ADD) begin
         assert_add_inverse_R2: assert ((ya_o - b_i) == a_i && (yb_o - lane_b[1]) == a_i);
      end
      if (op == OP_SUB) begin
         assert_sub_inverse_R3: assert ((ya_o + b_i) == a_i && (yb_o + lane_b[1]) == a_i);
      end
      if (op == OP_MUL && !MUL_SIGNED && b_i == {{(DATA_W-1){1'b0}}, 1'b1}) begin
         assert_mul_unit_R4: assert (ya_o == '0 && yb_o == a_i);
      end
      if (op == OP_ANDOR) begin
         assert_and_within_or_R5: assert ((ya_o & ~yb_o) == '0);
      end
      if (op == OP_XOR) begin
         assert_xor_complement_R6: assert (ya_o == ~yb_o);
      end
      if (op == OP_SWAP) begin
         assert_swap_undo_R7: assert ({ya_o[HALF_W-1:0], ya_o[DATA_W-1:HALF_W]} == a_i);
      end
      if (op == OP_RSVD) begin
         assert_reserved_zero_R8: assert (ya_o == '0 && yb_o == '0);
      end
      if (!is_arith) begin
         assert_no_cv_R12: assert (flags_a_o[1:0] == 2'b00 && flags_b_o[1:0] == 2'b00);
      end
   end
endmodule

// File: tb/pair_alu_tb_top.sv
`timescale 1ns/1ps
module pair_alu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a, b;
   logic [2:0]  op;
   logic [31:0] ya, yb;
   logic [3:0]  fa, fb;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   pair_alu dut_i (
      .a_i       (a),
      .b_i       (b),
      .op_i      (op),
      .ya_o      (ya),
      .yb_o      (yb),
      .flags_a_o (fa),
      .flags_b_o (fb)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] sx16(input logic [31:0] v);
      return {{16{v[15]}}, v[15:0]};
   endfunction

   // returns {C, V, result}
   function automatic logic [33:0] ref_as(input logic [31:0] x, input logic [31:0] y,
                                          input bit sub);
      logic [32:0] s;
      logic        c, v;
      if (!sub) begin
         s = {1'b0, x} + {1'b0, y};
         c = s[32];
         v = (x[31] == y[31]) && (s[31] != x[31]);
      end else begin
         s = {1'b0, x} - {1'b0, y};
         c = (x < y);
         v = (x[31] != y[31]) && (s[31] != x[31]);
      end
      return {c, v, s[31:0]};
   endfunction

   function automatic logic [3:0] zn(input logic [31:0] r);
      return {(r == 32'h0), r[31], 2'b00};
   endfunction

   task automatic apply(input logic [31:0] av, input logic [31:0] bv, input logic [2:0] ov);
      @(negedge clk);
      a = av; b = bv; op = ov;
      #1;
   endtask

   task automatic t_reset;
      // R1 R9: idle inputs of zero under pass give zero results with Z set
      check("R1", "reset ya", ya, 32'h0);
      check("R9", "reset flags a", {28'h0, fa}, 32'h8);
      check("R9", "reset flags b", {28'h0, fb}, 32'h8);
   endtask

   task automatic t_pass(input logic [31:0] av, input logic [31:0] bv);
      apply(av, bv, 3'b000);
      check("R1", "pass ya", ya, av);
      check("R1", "pass yb", yb, bv);
      check("R9", "pass flags a", {28'h0, fa}, {28'h0, zn(av)});
      check("R12", "pass flags b", {28'h0, fb}, {28'h0, zn(bv)});
   endtask

   task automatic t_arith(input logic [31:0] av, input logic [31:0] bv, input bit sub);
      logic [33:0] ra, rb;
      string rq;
      string rf;
      ra = ref_as(av, bv, sub);
      rb = ref_as(av, sx16(bv), sub);
      rq = sub ? "R3" : "R2";
      rf = sub ? "R11" : "R10";
      apply(av, bv, sub ? 3'b010 : 3'b001);
      check(rq, "ya", ya, ra[31:0]);
      check(rq, "yb", yb, rb[31:0]);
      check(rf, "flags a", {28'h0, fa},
            {28'h0, (ra[31:0] == 0), ra[31], ra[33], ra[32]});
      check(rf, "flags b", {28'h0, fb},
            {28'h0, (rb[31:0] == 0), rb[31], rb[33], rb[32]});
   endtask

   task automatic t_mul(input logic [31:0] av, input logic [31:0] bv);
      logic [63:0] p;
      p = {32'h0, av} * {32'h0, bv};
      apply(av, bv, 3'b011);
      check("R4", "mul msw", ya, p[63:32]);
      check("R4", "mul lsw", yb, p[31:0]);
      check("R12", "mul flags a", {28'h0, fa}, {28'h0, zn(p[63:32])});
   endtask

   task automatic t_logic(input logic [31:0] av, input logic [31:0] bv);
      apply(av, bv, 3'b100);
      check("R5", "and", ya, av & bv);
      check("R5", "or", yb, av | bv);
      apply(av, bv, 3'b101);
      check("R6", "xor", ya, av ^ bv);
      check("R6", "xnor", yb, ~(av ^ bv));
      check("R9", "xor flags a", {28'h0, fa}, {28'h0, zn(av ^ bv)});
      check("R12", "xnor flags b", {28'h0, fb}, {28'h0, zn(~(av ^ bv))});
   endtask

   task automatic t_swap(input logic [31:0] av, input logic [31:0] bv);
      apply(av, bv, 3'b111);
      check("R7", "swap a", ya, {av[15:0], av[31:16]});
      check("R7", "swap b", yb, {bv[15:0], bv[31:16]});
   endtask

   task automatic t_reserved(input logic [31:0] av, input logic [31:0] bv);
      apply(av, bv, 3'b110);
      check("R8", "rsvd ya", ya, 32'h0);
      check("R8", "rsvd yb", yb, 32'h0);
      check("R8", "rsvd flags a", {28'h0, fa}, 32'h8);
      check("R8", "rsvd flags b", {28'h0, fb}, 32'h8);
   endtask

   initial begin
      a = '0; b = '0; op = 3'b000;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_pass(32'h1234_5678, 32'h9ABC_DEF0);
      t_pass(32'h8000_0000, 32'h0000_0000);
      t_arith(32'h0000_0010, 32'h0001_FFF0, 1'b0);   // YB wraps to zero with carry
      t_arith(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);   // signed overflow
      t_arith(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      t_arith(32'h0000_0000, 32'h0000_0001, 1'b1);   // borrow
      t_arith(32'h8000_0000, 32'h0000_0001, 1'b1);   // signed overflow
      t_arith(32'h0000_5000, 32'h0000_8000, 1'b1);   // negative short offset
      t_arith(32'h1234_0000, 32'h1234_0000, 1'b1);   // zero result
      t_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      t_mul(32'h0001_0000, 32'h0001_0000);
      t_mul(32'h1234_5678, 32'h0000_0001);
      t_logic(32'hF0F0_1234, 32'h0FF0_FFFF);
      t_logic(32'hA5A5_A5A5, 32'hA5A5_A5A5);
      t_swap(32'h1234_ABCD, 32'hFFFF_0000);
      t_reserved(32'hDEAD_BEEF, 32'h8000_0001);
      t_reserved(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule